// File: doc/BRIEF.md
# Time-Shared Carry Select Adder

This block adds two 32-bit operands and a carry-in, producing a 32-bit sum and a carry-out. The lower 16 bits go through a ripple-carry chain fed by the external carry-in. The upper 16 bits would normally need two speculative adders, one for each possible incoming carry. Here they use a single adder that is reused over two consecutive clock cycles.

A phase flip-flop alternates between a "one" cycle and a "zero" cycle. In the "one" cycle, the upper adder is given an assumed carry of one, and its sum and carry are written into a hold register. In the following "zero" cycle, the same adder is given an assumed carry of zero. The carry-out of the lower chain then chooses between the held carry-one result and the live carry-zero result. The chosen value, joined to the lower sum, is registered onto the outputs together with a one-cycle valid pulse.

The caller holds the operands for one "one" cycle and the "zero" cycle that follows it. One result is produced every two clock cycles.

Top module: `shared_csel_adder`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `valid`, `sum` and `cout` are all 0. The first cycle after reset is a "one" phase cycle. The first `valid` pulse therefore appears after the second rising edge with `rst` low.
- R2: After reset, `valid` is high for exactly one cycle out of every two. It never stays high for two cycles in a row.
- R3: If `a` and `b` are unchanged across a "one" cycle and the next "zero" cycle, then in the cycle where `valid` is high, `sum` equals bits 31:0 of a + b + cin. Here `cin` is the value sampled in the "zero" cycle.
- R4: Under the same conditions as R3, `cout` equals bit 32 of that 33-bit addition.
- R5: If the lower 16-bit addition (using `cin`) carries out in the "zero" cycle, then the upper sum and `cout` come from the upper operand bits sampled in the "one" cycle, plus one. Upper operand bits that change during the "zero" cycle have no effect on the result.
- R6: If the lower 16-bit addition does not carry out, then the upper sum and `cout` come from the upper operand bits sampled in the "zero" cycle, plus zero.
- R7: While `valid` is low, `sum` and `cout` keep the values they had in the preceding cycle.
- R8: The external `cin` enters at bit 0. With lower halves 0xFFFF and 0x0000 and `cin` = 1, the carry reaches bit 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Registered 32-bit sum |
| cout | output | 1 | Registered carry out of bit 31 |
| valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to provoke is a result that actually depends on the hold register. While the operands stay steady, the carry-one and carry-zero paths add the same upper bits, so a design that ignored the held value would still look correct. The bench therefore changes only the upper operand bits between the "one" cycle and the "zero" cycle, with lower halves chosen to force a lower carry or to prevent one. A lower carry must return the stored sum of the old upper bits. No lower carry must return the sum of the new upper bits. A cycle model in the bench repeats this comparison on every clock during random traffic.

// File: rtl/shared_csel_pkg.sv
package shared_csel_pkg;

    typedef enum logic {
        PH_ZERO = 1'b0,
        PH_ONE  = 1'b1
    } phase_e;

    function automatic logic phase_carry(input phase_e ph);
        return (ph == PH_ONE);
    endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        logic g;
        assign p          = x[i] ^ y[i];
        assign g          = x[i] & y[i];
        assign s[i]       = p ^ chain[i];
        assign chain[i+1] = g | (p & chain[i]);
    end

    assign co = chain[W];

endmodule

// File: rtl/csel_shared_upper.sv
module csel_shared_upper
    import shared_csel_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  phase_e       phase,
    output logic [W-1:0] s,
    output logic         co
);
    logic assumed_c;

    assign assumed_c = phase_carry(phase);

    csel_ripple #(.W(W)) u_core (
        .x  (x),
        .y  (y),
        .ci (assumed_c),
        .s  (s),
        .co (co)
    );

endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
    parameter int W = 16
) (
    input  logic         take_one,
    input  logic [W-1:0] s_one,
    input  logic         c_one,
    input  logic [W-1:0] s_zero,
    input  logic         c_zero,
    output logic [W-1:0] s,
    output logic         co
);
    always_comb begin
        if (take_one) begin
            s  = s_one;
            co = c_one;
        end else begin
            s  = s_zero;
            co = c_zero;
        end
    end

endmodule

// File: rtl/shared_csel_adder.sv
module shared_csel_adder
    import shared_csel_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int LOW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             valid
);
    localparam int UP_W = WIDTH - LOW_W;

    typedef struct packed {
        phase_e           phase;
        logic [UP_W-1:0]  hold_s;
        logic             hold_c;
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             valid;
    } state_t;

    localparam state_t ST_RST = '{
        phase:  PH_ONE,
        hold_s: '0,
        hold_c: 1'b0,
        sum:    '0,
        cout:   1'b0,
        valid:  1'b0
    };

    state_t st_d, st_q;

    logic [LOW_W-1:0] low_s;
    logic             low_c;
    logic [UP_W-1:0]  up_s;
    logic             up_c;
    logic [UP_W-1:0]  pick_s;
    logic             pick_c;
    logic             phase_hi;

    // Lower half: plain ripple chain using the real carry-in
    csel_ripple #(.W(LOW_W)) u_low (
        .x  (a[LOW_W-1:0]),
        .y  (b[LOW_W-1:0]),
        .ci (cin),
        .s  (low_s),
        .co (low_c)
    );

    // Upper half: one adder, assumed carry taken from the phase
    csel_shared_upper #(.W(UP_W)) u_up (
        .x     (a[WIDTH-1:LOW_W]),
        .y     (b[WIDTH-1:LOW_W]),
        .phase (st_q.phase),
        .s     (up_s),
        .co    (up_c)
    );

    // Lower carry chooses the held carry-one result or the live carry-zero one
    csel_pick #(.W(UP_W)) u_pick (
        .take_one (low_c),
        .s_one    (st_q.hold_s),
        .c_one    (st_q.hold_c),
        .s_zero   (up_s),
        .c_zero   (up_c),
        .s        (pick_s),
        .co       (pick_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (st_q.phase == PH_ONE) begin
            st_d.hold_s = up_s;
            st_d.hold_c = up_c;
            st_d.phase  = PH_ZERO;
        end else begin
            st_d.sum   = {pick_s, low_s};
            st_d.cout  = pick_c;
            st_d.valid = 1'b1;
            st_d.phase = PH_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_hi = (st_q.phase == PH_ONE);
    assign sum      = st_q.sum;
    assign cout     = st_q.cout;
    assign valid    = st_q.valid;

endmodule

// File: rtl/shared_csel_adder_chk.sv
module shared_csel_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             valid,
    input logic             phase_hi
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (valid) seen_q <= 1'b1;
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);  // R2

    AST_VALID_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !valid) |=> valid);  // R2

    AST_VALID_IN_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        valid |-> phase_hi);  // R2

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(sum) && $stable(cout)));  // R7

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!phase_hi && $stable(a) && $stable(b)) |=>
        ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)})));  // R3

endmodule

bind shared_csel_adder shared_csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a        (a),
    .b        (b),
    .cin      (cin),
    .sum      (sum),
    .cout     (cout),
    .valid    (valid),
    .phase_hi (phase_hi)
);

// File: tb/shared_csel_adder_test.sv
`timescale 1ns/1ps
module shared_csel_adder_test;

    localparam int W = 32;
    localparam int H = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    logic         valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shared_csel_adder uut (
        .clk   (clk),
        .rst   (rst),
        .a     (a),
        .b     (b),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout),
        .valid (valid)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model of phase, hold value and outputs
    bit           ph_m;
    logic [H:0]   held_m;
    logic [W-1:0] exp_sum;
    logic         exp_cout;
    logic         exp_valid;
    logic         exp_lowc;
    logic [H:0]   lo_t;
    logic [H:0]   up_t;

    always @(posedge clk) begin
        if (rst) begin
            ph_m      <= 1'b1;
            exp_sum   <= '0;
            exp_cout  <= 1'b0;
            exp_valid <= 1'b0;
            exp_lowc  <= 1'b0;
        end else if (ph_m) begin
            held_m    <= {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + 17'd1;
            exp_valid <= 1'b0;
            ph_m      <= 1'b0;
        end else begin
            lo_t = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {16'd0, cin};
            up_t = lo_t[H] ? held_m : ({1'b0, a[W-1:H]} + {1'b0, b[W-1:H]});
            exp_sum   <= {up_t[H-1:0], lo_t[H-1:0]};
            exp_cout  <= up_t[H];
            exp_lowc  <= lo_t[H];
            exp_valid <= 1'b1;
            ph_m      <= 1'b1;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(valid == exp_valid, "R2 valid", valid, exp_valid);
            if (valid)
                check({cout, sum} == {exp_cout, exp_sum}, exp_lowc ? "R5 model" : "R6 model",
                      {cout, sum}, {exp_cout, exp_sum});
            else
                check({cout, sum} == {exp_cout, exp_sum}, "R7 hold", {cout, sum}, {exp_cout, exp_sum});
        end
    end

    task automatic to_one_phase();
        @(negedge clk);
        while (!ph_m) @(negedge clk);
    endtask

    task automatic op(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
        logic [W:0] ref_v;
        to_one_phase();
        a = x; b = y; cin = c;
        ref_v = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        @(negedge clk);
        @(negedge clk);
        check(valid == 1'b1, {tag, " R2 pulse"}, valid, 1);
        check(sum == ref_v[W-1:0], {tag, " R3 sum"}, sum, ref_v[W-1:0]);
        check(cout == ref_v[W], {tag, " R4 cout"}, cout, ref_v[W]);
    endtask

    // Upper bits change between the two phases
    task automatic split(input logic [W-1:0] x1, input logic [W-1:0] y1,
                         input logic [H-1:0] xh2, input logic [H-1:0] yh2, input logic c);
        logic [H:0] lo_v;
        logic [H:0] up_v;
        to_one_phase();
        a = x1; b = y1; cin = c;
        @(negedge clk);
        a[W-1:H] = xh2; b[W-1:H] = yh2;
        lo_v = {1'b0, x1[H-1:0]} + {1'b0, y1[H-1:0]} + {16'd0, c};
        up_v = lo_v[H] ? ({1'b0, x1[W-1:H]} + {1'b0, y1[W-1:H]} + 17'd1)
                       : ({1'b0, xh2} + {1'b0, yh2});
        @(negedge clk);
        check({cout, sum} == {up_v, lo_v[H-1:0]}, lo_v[H] ? "R5 split" : "R6 split",
              {cout, sum}, {up_v, lo_v[H-1:0]});
    endtask

    initial begin
        a = 32'hDEAD_BEEF; b = 32'h1234_5678; cin = 1'b1;
        repeat (4) @(negedge clk);
        check({valid, cout, sum} == '0, "R1 in reset", {valid, cout, sum}, 0);
        rst = 1'b0;
        a = 32'h0000_0003; b = 32'h0000_0004; cin = 1'b0;
        @(negedge clk);
        check(valid == 1'b0, "R1 first edge", valid, 0);
        check({cout, sum} == '0, "R1 first edge out", {cout, sum}, 0);
        @(negedge clk);
        check(valid == 1'b1, "R1 first pulse", valid, 1);
        check(sum == 32'd7, "R1 first sum", sum, 7);

        op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "ones c0");
        op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "ones c1");
        op(32'h0, 32'h0, 1'b0, "zero c0");
        op(32'h0, 32'h0, 1'b1, "zero c1");
        op(32'hFFFF_FFFF, 32'h0, 1'b1, "wrap");
        op(32'h0000_FFFF, 32'h0, 1'b1, "R8 cin ripple");
        check(sum == 32'h0001_0000, "R8 carry to bit16", sum, 32'h0001_0000);
        op(32'h0000_FFFF, 32'h0, 1'b0, "R8 no cin");
        op(32'h8000_0000, 32'h8000_0000, 1'b0, "top carry");

        split(32'h1111_FFFF, 32'h2222_0001, 16'hAAAA, 16'h5555, 1'b0);
        split(32'h7FFF_8000, 32'h0000_8000, 16'h0001, 16'h0001, 1'b0);
        split(32'hFFFF_0001, 32'h0000_0002, 16'h1234, 16'h4321, 1'b0);
        split(32'h0000_0000, 32'h0000_0000, 16'hFFFF, 16'hFFFF, 1'b0);
        split(32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 16'h0000, 1'b1);

        for (int i = 0; i < 200; i++)
            op($urandom, $urandom, 1'($urandom), "random");

        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            a = $urandom; b = $urandom; cin = 1'($urandom);
        end

        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule